// File: doc/BRIEF.md
# Split-Word FIFO Bus Access Bridge

This block connects a 16-bit register bus to a pair of 32-bit-wide FIFOs, one for transmit and one for receive. Words wider than one bus transfer are moved in two halves. For transmit, software first stages the upper half in a high-half register, then writes the lower half; that second write pushes the joined 32-bit word. For receive, a read of the lower half pops the FIFO head, returns its lower half and latches its upper half, which a later high-half read returns.

An optional byte exchange lets a serial link that carries 8-bit data pack two bytes into each 16-bit bus transfer in the order software expects. The exchange applies to every half-word crossing the bus, in both directions, and uses the swap control as it stands during that transfer. The FIFOs sit outside this block. The transmit FIFO is accepted to take a word in the cycle that the push strobe is high. The receive FIFO is expected to present its head word while it is not empty, and to drop that word in the cycle that the pop strobe is high.

Top module: `fifo_split_bridge`

## Requirements
- R1: After reset the staged upper half and the latched receive upper half are zero and bus_rdata is zero, so a low write with no prior high write pushes an upper half of 0x0000 and a high read returns 0x0000.
- R2: A write with bus_sel = 1 (high half) stores the half-word and raises no tx_push.
- R3: A write with bus_sel = 0 (low half) while tx_full is 0 raises tx_push in that same cycle, with tx_word[31:16] equal to the staged upper half and tx_word[15:0] equal to the written half-word.
- R4: A low-half write while tx_full is 1 is dropped: tx_push stays 0 and the staged upper half is unchanged.
- R5: The staged upper half keeps its value across any number of low-half writes until the next high-half write.
- R6: A read with bus_sel = 0 while rx_empty is 0 raises rx_pop in that same cycle, and bus_rdata shows rx_word[15:0] from the next cycle on.
- R7: A low-half read while rx_empty is 1 raises no rx_pop, and bus_rdata shows 0x0000 from the next cycle on.
- R8: A read with bus_sel = 1 returns rx_word[31:16] of the most recent successful pop on bus_rdata in the next cycle. That value stays the same through empty reads and through any other access until the next successful pop.
- R9: While swap_en is 1, bits [15:8] and [7:0] of each half-word are exchanged as it crosses the bus: on staged high writes, on pushed low halves, on low-half read data and on high-half read data. The swap_en value during the transfer decides.
- R10: The select codes 2 and 3 are reserved. A write to them changes nothing and pushes nothing. A read of them pops nothing and returns 0x0000.
- R11: bus_rdata changes only in the cycle after a read, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per transfer |
| bus_rd | input | 1 | Bus read strobe, one cycle per transfer |
| bus_sel | input | 2 | Register select: 0 low half, 1 high half, 2 and 3 reserved |
| bus_wdata | input | 16 | Bus write data |
| swap_en | input | 1 | Byte exchange enable for bus transfers |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_empty | input | 1 | Receive FIFO empty flag |
| rx_word | input | 32 | Receive FIFO head word |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_word | output | 32 | Word pushed into the transmit FIFO |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| bus_rdata | output | 16 | Bus read data, valid the cycle after a read |

## Verification
The assertions assume that tx_full and rx_empty describe the FIFOs in the current cycle, and that rx_word holds the head entry whenever rx_empty is low, so that a pop captures a defined word. They also assume that the write and read strobes are known (not X) once reset is released. The bench drives these flags and the head word directly from each stimulus row as values held for a whole cycle. It changes them only at the falling edge, so every flag and head word that a strobe meets is a settled, self-consistent FIFO state.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_LOW  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_HIGH = 2'd1;

endpackage

// File: rtl/sfb_byte_swap.sv
module sfb_byte_swap #(
    parameter int HALF_W = 16
) (
    input  logic              en,
    input  logic [HALF_W-1:0] din,
    output logic [HALF_W-1:0] dout
);

    localparam int NBYTES = HALF_W / 8;

    logic [HALF_W-1:0] reversed;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign reversed[b*8 +: 8] = din[(NBYTES-1-b)*8 +: 8];
    end

    assign dout = en ? reversed : din;

endmodule

// File: rtl/sfb_tx_stage.sv
module sfb_tx_stage #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hi_wr,
    input  logic                lo_wr,
    input  logic                tx_full,
    input  logic [HALF_W-1:0]   wdata_bus,
    output logic                tx_push,
    output logic [2*HALF_W-1:0] tx_word
);

    typedef struct packed {
        logic [HALF_W-1:0] hi_stage;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        tx_push = 1'b0;
        if (hi_wr) begin
            st_d.hi_stage = wdata_bus;
        end
        if (lo_wr && !tx_full) begin
            tx_push = 1'b1;
        end
        tx_word = {st_q.hi_stage, wdata_bus};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sfb_rx_capture.sv
module sfb_rx_capture #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lo_rd,
    input  logic                hi_rd,
    input  logic                any_rd,
    input  logic                swap_en,
    input  logic                rx_empty,
    input  logic [2*HALF_W-1:0] rx_word,
    output logic                rx_pop,
    output logic [HALF_W-1:0]   rdata
);

    typedef struct packed {
        logic [HALF_W-1:0] hi_latch;
        logic [HALF_W-1:0] rdata;
    } rx_state_t;

    rx_state_t         st_d, st_q;
    logic [HALF_W-1:0] src_raw;
    logic [HALF_W-1:0] src_bus;
    logic              pop_ok;

    assign pop_ok = lo_rd && !rx_empty;

    always_comb begin
        src_raw = '0;
        if (lo_rd) begin
            src_raw = pop_ok ? rx_word[HALF_W-1:0] : '0;
        end else if (hi_rd) begin
            src_raw = st_q.hi_latch;
        end
    end

    sfb_byte_swap #(
        .HALF_W(HALF_W)
    ) u_rd_swap (
        .en  (swap_en),
        .din (src_raw),
        .dout(src_bus)
    );

    always_comb begin
        st_d   = st_q;
        rx_pop = pop_ok;
        if (pop_ok) begin
            st_d.hi_latch = rx_word[2*HALF_W-1:HALF_W];
        end
        if (any_rd) begin
            st_d.rdata = src_bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/fifo_split_bridge.sv
module fifo_split_bridge #(
    parameter int HALF_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [SEL_W-1:0]    bus_sel,
    input  logic [HALF_W-1:0]   bus_wdata,
    input  logic                swap_en,
    input  logic                tx_full,
    input  logic                rx_empty,
    input  logic [2*HALF_W-1:0] rx_word,
    output logic                tx_push,
    output logic [2*HALF_W-1:0] tx_word,
    output logic                rx_pop,
    output logic [HALF_W-1:0]   bus_rdata
);

    import sfb_pkg::*;

    localparam int WORD_W = 2 * HALF_W;

    logic              sel_lo, sel_hi;
    logic              lo_wr, hi_wr, lo_rd, hi_rd;
    logic [HALF_W-1:0] wdata_bus;
    logic [WORD_W-1:0] tx_word_int;

    assign sel_lo = (bus_sel == SEL_W'(SEL_LOW));
    assign sel_hi = (bus_sel == SEL_W'(SEL_HIGH));
    assign lo_wr  = bus_wr && sel_lo;
    assign hi_wr  = bus_wr && sel_hi;
    assign lo_rd  = bus_rd && sel_lo;
    assign hi_rd  = bus_rd && sel_hi;

    sfb_byte_swap #(
        .HALF_W(HALF_W)
    ) u_wr_swap (
        .en  (swap_en),
        .din (bus_wdata),
        .dout(wdata_bus)
    );

    sfb_tx_stage #(
        .HALF_W(HALF_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_wr    (hi_wr),
        .lo_wr    (lo_wr),
        .tx_full  (tx_full),
        .wdata_bus(wdata_bus),
        .tx_push  (tx_push),
        .tx_word  (tx_word_int)
    );

    assign tx_word = tx_word_int;

    sfb_rx_capture #(
        .HALF_W(HALF_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_rd   (lo_rd),
        .hi_rd   (hi_rd),
        .any_rd  (bus_rd),
        .swap_en (swap_en),
        .rx_empty(rx_empty),
        .rx_word (rx_word),
        .rx_pop  (rx_pop),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
    parameter int HALF_W = 16,
    parameter int SEL_W  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [SEL_W-1:0]    bus_sel,
    input logic [HALF_W-1:0]   bus_wdata,
    input logic                swap_en,
    input logic                tx_full,
    input logic                rx_empty,
    input logic [2*HALF_W-1:0] rx_word,
    input logic                tx_push,
    input logic [2*HALF_W-1:0] tx_word,
    input logic                rx_pop,
    input logic [HALF_W-1:0]   bus_rdata
);

    logic [HALF_W-1:0] shadow_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_hi <= '0;
        end else if (bus_wr && bus_sel == SEL_W'(1)) begin
            shadow_hi <= swap_en ? {bus_wdata[7:0], bus_wdata[HALF_W-1:8]} : bus_wdata;
        end
    end

    // R2: high-half write never pushes
    a_r2_high_write_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_W'(1)) |-> !tx_push);

    // R3: a push only comes from a low-half write and carries the staged upper half
    a_r3_push_source: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (bus_wr && bus_sel == SEL_W'(0)));

    a_r3_push_upper: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (tx_word[2*HALF_W-1:HALF_W] == shadow_hi));

    // R4: no push into a full FIFO
    a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_push);

    // R6: unswapped pop returns the lower half of the head word next cycle
    a_r6_pop_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !swap_en) |=> (bus_rdata == $past(rx_word[HALF_W-1:0])));

    // R7: no pop from an empty FIFO, and the read returns zero
    a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !rx_pop);

    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == SEL_W'(0) && rx_empty) |=> (bus_rdata == '0));

    // R10: reserved selects move nothing
    a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel[SEL_W-1]) |-> (!tx_push && !rx_pop));

    // R11: read data holds when there is no read
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind fifo_split_bridge sfb_checker #(
    .HALF_W(HALF_W),
    .SEL_W (SEL_W)
) u_sfb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_sel  (bus_sel),
    .bus_wdata(bus_wdata),
    .swap_en  (swap_en),
    .tx_full  (tx_full),
    .rx_empty (rx_empty),
    .rx_word  (rx_word),
    .tx_push  (tx_push),
    .tx_word  (tx_word),
    .rx_pop   (rx_pop),
    .bus_rdata(bus_rdata)
);

// File: tb/fifo_split_bridge_bench.sv
module fifo_split_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic        swap_en = 1'b0;
    logic        tx_full = 1'b0;
    logic        rx_empty = 1'b1;
    logic [31:0] rx_word = 32'h0;
    logic        tx_push;
    logic [31:0] tx_word;
    logic        rx_pop;
    logic [15:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fifo_split_bridge u_fifo_split_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_sel  (bus_sel),
        .bus_wdata(bus_wdata),
        .swap_en  (swap_en),
        .tx_full  (tx_full),
        .rx_empty (rx_empty),
        .rx_word  (rx_word),
        .tx_push  (tx_push),
        .tx_word  (tx_word),
        .rx_pop   (rx_pop),
        .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [1:0]  sel;
        logic [15:0] wd;
        logic        sw;
        logic        full;
        logic        empty;
        logic [31:0] rw;
        logic        ep;
        logic        eo;
        logic [31:0] ew;
        logic        cr;
        logic [15:0] er;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;

    // wr rd sel wd sw full empty rw | push pop word | chk_rd rdata | req
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,2'd1,16'h0000,1'b0,1'b0,1'b1,32'h0,         1'b0,1'b0,32'h0,         1'b1,16'h0000, 8'd1},  // R1 high read after reset
        '{1'b1,1'b0,2'd0,16'h1234,1'b0,1'b0,1'b1,32'h0,         1'b1,1'b0,32'h0000_1234, 1'b0,16'h0000, 8'd1},  // R1 zero staged upper
        '{1'b1,1'b0,2'd1,16'hABCD,1'b0,1'b0,1'b1,32'h0,         1'b0,1'b0,32'h0,         1'b0,16'h0000, 8'd2},  // R2 stage only
        '{1'b1,1'b0,2'd0,16'h5678,1'b0,1'b0,1'b1,32'h0,         1'b1,1'b0,32'hABCD_5678, 1'b0,16'h0000, 8'd3},  // R3 combined push
        '{1'b1,1'b0,2'd0,16'h9999,1'b0,1'b1,1'b1,32'h0,         1'b0,1'b0,32'h0,         1'b0,16'h0000, 8'd4},  // R4 full drop
        '{1'b1,1'b0,2'd0,16'h0001,1'b0,1'b0,1'b1,32'h0,         1'b1,1'b0,32'hABCD_0001, 1'b0,16'h0000, 8'd5},  // R5 staged persists
        '{1'b0,1'b1,2'd0,16'h0000,1'b0,1'b0,1'b0,32'hDEAD_BEEF, 1'b0,1'b1,32'h0,         1'b1,16'hBEEF, 8'd6},  // R6 pop low half
        '{1'b0,1'b1,2'd1,16'h0000,1'b0,1'b0,1'b0,32'h5555_6666, 1'b0,1'b0,32'h0,         1'b1,16'hDEAD, 8'd8},  // R8 latched upper
        '{1'b0,1'b1,2'd0,16'h0000,1'b0,1'b0,1'b1,32'h1111_2222, 1'b0,1'b0,32'h0,         1'b1,16'h0000, 8'd7},  // R7 empty read
        '{1'b0,1'b1,2'd1,16'h0000,1'b0,1'b0,1'b1,32'h0,         1'b0,1'b0,32'h0,         1'b1,16'hDEAD, 8'd8},  // R8 stable after empty read
        '{1'b1,1'b0,2'd1,16'h1122,1'b1,1'b0,1'b1,32'h0,         1'b0,1'b0,32'h0,         1'b0,16'h0000, 8'd9},  // R9 swapped stage
        '{1'b1,1'b0,2'd0,16'h3344,1'b1,1'b0,1'b1,32'h0,         1'b1,1'b0,32'h2211_4433, 1'b0,16'h0000, 8'd9},  // R9 swapped push
        '{1'b0,1'b1,2'd0,16'h0000,1'b1,1'b0,1'b0,32'hA1B2_C3D4, 1'b0,1'b1,32'h0,         1'b1,16'hD4C3, 8'd9},  // R9 swapped low read
        '{1'b0,1'b1,2'd1,16'h0000,1'b1,1'b0,1'b1,32'h0,         1'b0,1'b0,32'h0,         1'b1,16'hB2A1, 8'd9},  // R9 swapped high read
        '{1'b0,1'b1,2'd1,16'h0000,1'b0,1'b0,1'b1,32'h0,         1'b0,1'b0,32'h0,         1'b1,16'hA1B2, 8'd9},  // R9 swap at transfer time
        '{1'b1,1'b0,2'd2,16'hFFFF,1'b0,1'b0,1'b1,32'h0,         1'b0,1'b0,32'h0,         1'b0,16'h0000, 8'd10}, // R10 reserved write
        '{1'b0,1'b1,2'd3,16'h0000,1'b0,1'b0,1'b0,32'h7777_8888, 1'b0,1'b0,32'h0,         1'b1,16'h0000, 8'd10}, // R10 reserved read
        '{1'b1,1'b0,2'd0,16'h0000,1'b0,1'b0,1'b1,32'h0,         1'b1,1'b0,32'h2211_0000, 1'b0,16'h0000, 8'd10}  // R10 staging untouched
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        bus_sel = 2'd0;
        bus_wdata = 16'h0;
        swap_en = 1'b0;
        tx_full = 1'b0;
        rx_empty = 1'b1;
        rx_word = 32'h0;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        idle();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset tx_push", {31'b0, tx_push}, 32'h0);
        check("R1 reset rx_pop", {31'b0, rx_pop}, 32'h0);
        check("R1 reset bus_rdata", {16'h0, bus_rdata}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr    = VECS[i].wr;
            bus_rd    = VECS[i].rd;
            bus_sel   = VECS[i].sel;
            bus_wdata = VECS[i].wd;
            swap_en   = VECS[i].sw;
            tx_full   = VECS[i].full;
            rx_empty  = VECS[i].empty;
            rx_word   = VECS[i].rw;
            #2;
            check($sformatf("R%0d vec%0d tx_push", VECS[i].req, i), {31'b0, tx_push}, {31'b0, VECS[i].ep});
            check($sformatf("R%0d vec%0d rx_pop", VECS[i].req, i), {31'b0, rx_pop}, {31'b0, VECS[i].eo});
            if (VECS[i].ep) begin
                check($sformatf("R%0d vec%0d tx_word", VECS[i].req, i), tx_word, VECS[i].ew);
            end
            @(posedge clk);
            #1;
            if (VECS[i].cr) begin
                check($sformatf("R%0d vec%0d bus_rdata", VECS[i].req, i), {16'h0, bus_rdata}, {16'h0, VECS[i].er});
            end
        end

        // R11: idle cycles leave the last read data (0x0000 from vector 16) in place
        @(negedge clk);
        idle();
        bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = 16'h4242;
        @(negedge clk);
        idle();
        repeat (2) @(negedge clk);
        check("R11 rdata held without read", {16'h0, bus_rdata}, 32'h0);

        // R11: a pop followed by idle cycles keeps the popped data
        bus_rd = 1'b1; bus_sel = 2'd0; rx_empty = 1'b0; rx_word = 32'hCAFE_F00D;
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        check("R11 popped data held", {16'h0, bus_rdata}, 32'h0000_F00D);

        // R1: reset clears staged and latched halves
        rst_n = 1'b0;
        #2;
        check("R1 rdata cleared by reset", {16'h0, bus_rdata}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 2'd0; bus_wdata = 16'h0005;
        #2;
        check("R1 staged upper zero after reset", tx_word, 32'h0000_0005);
        check("R1 push after reset", {31'b0, tx_push}, 32'h1);
        @(negedge clk);
        idle();
        bus_rd = 1'b1; bus_sel = 2'd1;
        @(posedge clk);
        #1;
        check("R1 latched upper zero after reset", {16'h0, bus_rdata}, 32'h0);
        @(negedge clk);
        idle();

        // R4: full drop then push keeps staged upper
        bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = 16'h0F0F;
        @(negedge clk);
        bus_sel = 2'd0; bus_wdata = 16'h1111; tx_full = 1'b1;
        #2;
        check("R4 no push while full", {31'b0, tx_push}, 32'h0);
        @(negedge clk);
        tx_full = 1'b0; bus_wdata = 16'h2222;
        #2;
        check("R4 staged upper kept after drop", tx_word, 32'h0F0F_2222);
        @(negedge clk);
        idle();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule